// File: doc/BRIEF.md
# Ultrasound Burst Waveform Generator

This block makes the logic-level drive pattern for an eight-line unipolar high-voltage pulser. It runs from a 40 MHz reference clock. Five push buttons set how it behaves. One picks the number of pulses in a burst. One steps the pulse frequency down a binary ladder of the reference. One lengthens the quiet time between bursts. One switches the pulser enable on or off. One moves between pulsed imaging (B-mode) and continuous wave (CW).

Each button goes through a synchroniser and a debouncer, so one press advances one setting. A sequencer then runs the channel drive. In B-mode it plays a burst of whole square-wave periods, followed by a low gap, and repeats. In CW it plays an endless 50% square wave. The mode-control output tells the pulser stage which mode is active, and the enable output turns it on.

Top module: `burst_pulser_seq`

## Requirements
- R1: After reset: chip_en_o is 0, mode_ctrl_o is 1 (B-mode), every drive line is 0, burst length is "none", the divider is 2 (half period of 1 reference cycle), and the gap step is 0.
- R2: A button counts as pressed only after its synchronised level has stayed high for DEB_CYCLES cycles. A shorter glitch does nothing. A press that is held advances its setting exactly once.
- R3: The enable button toggles chip_en_o. While chip_en_o is 0, all drive lines are 0.
- R4: The mode button toggles mode_ctrl_o: 1 means B-mode and 0 means CW.
- R5: The wave button cycles the burst length none, 1, 3, 7 and then back to none. In B-mode a burst is that many periods. Each period is high for one half period, then low for one half period. "none" gives no pulses.
- R6: The frequency button cycles the divider k = 0..5, which is a period of 2^(k+1) reference cycles (20 down to 0.625 MHz). After k = 5 it wraps to 0.
- R7: The gap button cycles k = 0..7 and wraps to 0. After the last low half of a burst, the lines stay low for TICKS_PER_US*2^k cycles (1 to 128 µs) before the next burst starts. So the B-mode repetition period is 2*N*half + gap.
- R8: In CW the lines carry a continuous square wave with a period of 2*half and 50% duty. Burst length and gap settings have no effect.
- R9: A frequency change is taken only when a burst starts (in CW, when a period starts). Every pulse within one burst has the same width.
- R10: All eight drive lines carry the same value in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 40 MHz reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wave_btn_i | input | 1 | Burst-length button, raw |
| freq_btn_i | input | 1 | Frequency button, raw |
| gap_btn_i | input | 1 | Off-time button, raw |
| en_btn_i | input | 1 | Enable toggle button, raw |
| mode_btn_i | input | 1 | B-mode/CW toggle button, raw |
| drive_o | output | N_CH | Channel drive lines |
| mode_ctrl_o | output | 1 | 1 = B-mode, 0 = CW |
| chip_en_o | output | 1 | Pulser enable |

## Verification
The frequency setting and the burst in progress can collide: a frequency press can be registered in the same cycle as a high or low half of a running burst. The bench provokes this with a 7-period burst at the slowest frequency and presses the frequency button about 100 cycles into that burst. It then measures each high run. All seven runs of that burst must keep the old width, and the first run of the next burst must have the new width. Steady-state settings are judged by counting high cycles and rising edges over a window that is exactly two repetition periods long, so the result does not depend on the phase of the window.

// File: rtl/pulser_pkg.sv
package pulser_pkg;
  localparam int WAVE_STEPS = 4;
  localparam int N_BTN      = 5;
  localparam int BTN_WAVE   = 0;
  localparam int BTN_FREQ   = 1;
  localparam int BTN_GAP    = 2;
  localparam int BTN_EN     = 3;
  localparam int BTN_MODE   = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_LO   = 2'd2,
    ST_GAP  = 2'd3
  } burst_st_e;
endpackage

// File: rtl/btn_cond.sv
module btn_cond #(
  parameter int DEB_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic press_o
);
  localparam int CW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;

  logic [1:0]    sync_q;
  logic          lvl_q;
  logic [CW-1:0] cnt_q;
  logic          done;

  assign done = (cnt_q == CW'(DEB_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      lvl_q   <= 1'b0;
      cnt_q   <= '0;
      press_o <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], btn_i};
      press_o <= 1'b0;
      if (sync_q[1] == lvl_q) begin
        cnt_q <= '0;
      end else if (done) begin
        cnt_q   <= '0;
        lvl_q   <= sync_q[1];
        press_o <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  one_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_o |=> !press_o);
endmodule

// File: rtl/step_cnt.sv
module step_cnt #(
  parameter int STEPS = 4,
  localparam int W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] val_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_o <= '0;
    else if (adv_i) val_o <= (val_o == W'(STEPS - 1)) ? '0 : val_o + 1'b1;
  end

  // R6
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && val_o == W'(STEPS - 1)) |=> val_o == '0);
  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(val_o));
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import pulser_pkg::*;
#(
  parameter int N_CH         = 8,
  parameter int TICKS_PER_US = 40,
  parameter int FREQ_STEPS   = 6,
  parameter int GAP_STEPS    = 8,
  localparam int WAVE_W = $clog2(WAVE_STEPS),
  localparam int FREQ_W = $clog2(FREQ_STEPS),
  localparam int GAP_W  = $clog2(GAP_STEPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cw_i,
  input  logic [WAVE_W-1:0] wave_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [GAP_W-1:0]  gap_i,
  output logic [N_CH-1:0]   drive_o
);
  localparam int CNT_W = $clog2(TICKS_PER_US << (GAP_STEPS - 1));
  localparam int CYC_W = (1 << WAVE_W) - 1;

  burst_st_e         st_q, start_st;
  logic [CNT_W-1:0]  cnt_q, half, gap_len;
  logic [FREQ_W-1:0] act_f_q;
  logic [CYC_W-1:0]  cyc_q, cyc_init;
  logic              half_end, gap_end, start, hi;

  assign half     = CNT_W'(1) << act_f_q;
  assign gap_len  = CNT_W'(TICKS_PER_US) << gap_i;
  assign half_end = (cnt_q >= half - 1'b1);
  assign gap_end  = (cnt_q >= gap_len - 1'b1);
  // pulses in burst minus one; unused when wave_i is zero
  assign cyc_init = CYC_W'(((CYC_W + 1)'(1) << wave_i) - (CYC_W + 1)'(2));
  assign start_st = (cw_i || wave_i != '0) ? ST_HI : ST_GAP;

  always_comb begin
    start = 1'b0;
    if (en_i) begin
      unique case (st_q)
        ST_IDLE: start = 1'b1;
        ST_LO:   start = half_end && cw_i;
        ST_GAP:  start = gap_end;
        default: start = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      act_f_q <= '0;
      cyc_q   <= '0;
    end else if (!en_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (start) begin
      st_q    <= start_st;
      cnt_q   <= '0;
      act_f_q <= freq_i;
      cyc_q   <= cyc_init;
    end else begin
      unique case (st_q)
        ST_HI: begin
          if (half_end) begin
            cnt_q <= '0;
            st_q  <= ST_LO;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_LO: begin
          if (half_end) begin
            cnt_q <= '0;
            if (cyc_q == '0) st_q <= ST_GAP;
            else begin
              cyc_q <= cyc_q - 1'b1;
              st_q  <= ST_HI;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_GAP:  cnt_q <= cnt_q + 1'b1;
        default: cnt_q <= '0;
      endcase
    end
  end

  assign hi = (st_q == ST_HI);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign drive_o[g] = hi;
  end

  // R3
  en_off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> drive_o == '0);
  // R5
  hi_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HI) |-> cnt_q < half);
  // R9
  freq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HI && !start) |=> act_f_q == $past(act_f_q));
endmodule

// File: rtl/burst_pulser_seq.sv
module burst_pulser_seq
  import pulser_pkg::*;
#(
  parameter int N_CH         = 8,
  parameter int TICKS_PER_US = 40,
  parameter int DEB_CYCLES   = 8,
  parameter int FREQ_STEPS   = 6,
  parameter int GAP_STEPS    = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wave_btn_i,
  input  logic            freq_btn_i,
  input  logic            gap_btn_i,
  input  logic            en_btn_i,
  input  logic            mode_btn_i,
  output logic [N_CH-1:0] drive_o,
  output logic            mode_ctrl_o,
  output logic            chip_en_o
);
  localparam int WAVE_W = $clog2(WAVE_STEPS);
  localparam int FREQ_W = $clog2(FREQ_STEPS);
  localparam int GAP_W  = $clog2(GAP_STEPS);

  logic [N_BTN-1:0]  btn_raw, press;
  logic [WAVE_W-1:0] wave_sel;
  logic [FREQ_W-1:0] freq_sel;
  logic [GAP_W-1:0]  gap_sel;
  logic              en_sel, cw_sel;

  assign btn_raw[BTN_WAVE] = wave_btn_i;
  assign btn_raw[BTN_FREQ] = freq_btn_i;
  assign btn_raw[BTN_GAP]  = gap_btn_i;
  assign btn_raw[BTN_EN]   = en_btn_i;
  assign btn_raw[BTN_MODE] = mode_btn_i;

  for (genvar b = 0; b < N_BTN; b++) begin : g_btn
    btn_cond #(.DEB_CYCLES(DEB_CYCLES)) u_btn (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .btn_i  (btn_raw[b]),
      .press_o(press[b])
    );
  end

  step_cnt #(.STEPS(WAVE_STEPS)) u_wave (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(press[BTN_WAVE]), .val_o(wave_sel));
  step_cnt #(.STEPS(FREQ_STEPS)) u_freq (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(press[BTN_FREQ]), .val_o(freq_sel));
  step_cnt #(.STEPS(GAP_STEPS)) u_gap (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(press[BTN_GAP]), .val_o(gap_sel));
  step_cnt #(.STEPS(2)) u_en (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(press[BTN_EN]), .val_o(en_sel));
  step_cnt #(.STEPS(2)) u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(press[BTN_MODE]), .val_o(cw_sel));

  burst_seq #(
    .N_CH(N_CH), .TICKS_PER_US(TICKS_PER_US),
    .FREQ_STEPS(FREQ_STEPS), .GAP_STEPS(GAP_STEPS)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_sel),
    .cw_i   (cw_sel),
    .wave_i (wave_sel),
    .freq_i (freq_sel),
    .gap_i  (gap_sel),
    .drive_o(drive_o)
  );

  assign mode_ctrl_o = ~cw_sel;
  assign chip_en_o   = en_sel;

  // R4
  mode_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !press[BTN_MODE] |=> $stable(mode_ctrl_o));
  // R3
  en_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press[BTN_EN] |=> chip_en_o != $past(chip_en_o));
endmodule

// File: tb/burst_pulser_seq_bench.sv
`timescale 1ns/1ps
module burst_pulser_seq_bench;
  localparam int CLK_PERIOD = 25;
  localparam int DEB        = 8;
  localparam int SETTLE     = 6000;
  localparam int NV         = 9;
  // {cw, wave, freq, gap, high cycles per period, rises per period, period}
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 2'd1, 3'd0, 3'd0, 16'd1,  4'd1, 16'd42},
    {1'b0, 2'd2, 3'd1, 3'd0, 16'd6,  4'd3, 16'd52},
    {1'b0, 2'd3, 3'd2, 3'd1, 16'd28, 4'd7, 16'd136},
    {1'b0, 2'd1, 3'd5, 3'd2, 16'd32, 4'd1, 16'd224},
    {1'b0, 2'd3, 3'd3, 3'd3, 16'd56, 4'd7, 16'd432},
    {1'b0, 2'd0, 3'd0, 3'd0, 16'd0,  4'd0, 16'd40},
    {1'b1, 2'd3, 3'd1, 3'd3, 16'd2,  4'd1, 16'd4},
    {1'b1, 2'd0, 3'd4, 3'd0, 16'd16, 4'd1, 16'd32},
    {1'b0, 2'd2, 3'd0, 3'd7, 16'd3,  4'd3, 16'd5126}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wave_b = 1'b0, freq_b = 1'b0, gap_b = 1'b0, en_b = 1'b0, mode_b = 1'b0;
  logic [7:0] drive;
  logic       mode_ctrl, chip_en;

  int checks = 0, failures = 0;
  int cur_w = 0, cur_f = 0, cur_g = 0, cur_cw = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  burst_pulser_seq u_burst_pulser_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .wave_btn_i(wave_b), .freq_btn_i(freq_b), .gap_btn_i(gap_b),
    .en_btn_i(en_b), .mode_btn_i(mode_b),
    .drive_o(drive), .mode_ctrl_o(mode_ctrl), .chip_en_o(chip_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_btn(input int b, input logic v);
    case (b)
      0: wave_b = v;
      1: freq_b = v;
      2: gap_b  = v;
      3: en_b   = v;
      default: mode_b = v;
    endcase
  endtask

  task automatic press(input int b, input int hold);
    set_btn(b, 1'b1);
    repeat (hold) @(negedge clk);
    set_btn(b, 1'b0);
    repeat (DEB + 12) @(negedge clk);
  endtask

  task automatic measure(input int len, output int hi, output int rises, output int mis);
    logic prev, cur;
    hi = 0; rises = 0; mis = 0;
    prev = drive[0];
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      cur = drive[0];
      if (cur && !prev) rises++;
      if (cur) hi++;
      if (drive != {8{cur}}) mis++;
      prev = cur;
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int hi, rises, mis, tw, tf, tg, tc, per;
    int runs [8];
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(chip_en == 1'b0, "R1", chip_en, 0);
    chk(mode_ctrl == 1'b1, "R1", mode_ctrl, 1);
    chk(drive == 8'h00, "R1", drive, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3: pulses selected but enable off -> lines stay low
    press(0, DEB + 10); cur_w = 1;
    measure(200, hi, rises, mis);
    chk(hi == 0, "R3", hi, 0);

    // R2: short glitch ignored
    set_btn(4, 1'b1); repeat (3) @(negedge clk); set_btn(4, 1'b0);
    repeat (40) @(negedge clk);
    chk(mode_ctrl == 1'b1, "R2", mode_ctrl, 1);
    // R2 R4: long hold advances once
    press(4, 100);
    chk(mode_ctrl == 1'b0, "R2 R4", mode_ctrl, 0);
    press(4, DEB + 10);
    chk(mode_ctrl == 1'b1, "R4", mode_ctrl, 1);

    press(3, DEB + 10);
    chk(chip_en == 1'b1, "R3", chip_en, 1);

    // table of settings and expected periodic shape
    for (int v = 0; v < NV; v++) begin
      tc = int'(VEC[v][44]);
      tw = int'(VEC[v][43:42]);
      tf = int'(VEC[v][41:39]);
      tg = int'(VEC[v][38:36]);
      per = int'(VEC[v][15:0]);
      while (cur_w != tw) begin press(0, DEB + 10); cur_w = (cur_w + 1) % 4; end
      while (cur_f != tf) begin press(1, DEB + 10); cur_f = (cur_f + 1) % 6; end
      while (cur_g != tg) begin press(2, DEB + 10); cur_g = (cur_g + 1) % 8; end
      if (cur_cw != tc) begin press(4, DEB + 10); cur_cw = tc; end
      repeat (SETTLE) @(negedge clk);
      measure(2 * per, hi, rises, mis);
      if (tc == 1) begin
        chk(hi == 2 * int'(VEC[v][35:20]), "R8", hi, 2 * int'(VEC[v][35:20]));
        chk(rises == 2 * int'(VEC[v][19:16]), "R8", rises, 2 * int'(VEC[v][19:16]));
        chk(mode_ctrl == 1'b0, "R4", mode_ctrl, 0);
      end else begin
        chk(hi == 2 * int'(VEC[v][35:20]), "R5 R6 R7", hi, 2 * int'(VEC[v][35:20]));
        chk(rises == 2 * int'(VEC[v][19:16]), "R5 R6 R7", rises, 2 * int'(VEC[v][19:16]));
      end
      chk(mis == 0, "R10", mis, 0);
    end

    // R9: frequency press in mid-burst (7 pulses, half 32, gap 40)
    press(0, DEB + 10); cur_w = 3;
    while (cur_f != 5) begin press(1, DEB + 10); cur_f = (cur_f + 1) % 6; end
    press(2, DEB + 10); cur_g = 0;
    repeat (SETTLE) @(negedge clk);
    begin
      int lows;
      lows = 0;
      while (!(drive[0] && lows > 40)) begin
        lows = drive[0] ? 0 : lows + 1;
        @(negedge clk);
      end
    end
    fork
      begin
        repeat (100) @(negedge clk);
        press(1, DEB + 10);
      end
      begin
        for (int r = 0; r < 8; r++) begin
          int len;
          while (!drive[0]) @(negedge clk);
          len = 0;
          while (drive[0]) begin len++; @(negedge clk); end
          runs[r] = len;
        end
      end
    join
    cur_f = 0;
    for (int r = 0; r < 7; r++) chk(runs[r] == 32, "R9", runs[r], 32);
    chk(runs[7] == 1, "R9", runs[7], 1);

    // R3: disable -> lines low
    press(3, DEB + 10);
    chk(chip_en == 1'b0, "R3", chip_en, 0);
    measure(300, hi, rises, mis);
    chk(hi == 0, "R3", hi, 0);

    finish_run();
  end
endmodule